// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general register store of a 32-bit processor whose architectural view of registers R0 to R15 depends on the current operating mode. Behind the sixteen names sit 31 physical 32-bit registers. A 5-bit mode code steers every access to the right physical copy. The fast-interrupt mode gets private copies of R8 to R14. The interrupt, supervisor, abort and undefined modes each get private copies of R13 (stack pointer) and R14 (link register) only. User and system modes work on the common set. R15 is the program counter and exists once for all modes.

The pipeline uses two combinational read ports and one general write port. A dedicated PC port updates R15. A subroutine-call strobe copies the current PC into R14 of the current mode. A separate link port lets the exception controller load R14 of a chosen target mode while the current mode is still the old one.

Top module: `bank_rf`

## Requirements
- R1: While rst_ni is low all 31 physical registers are held at zero, so every read in every mode returns 0 and pc_o is 0.
- R2: Mode codes are user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Any other code behaves exactly like user mode for reads and writes.
- R3: In fast-interrupt mode, R8 to R14 address private copies. Writes to them are not seen in any other mode. R0 to R7 and R15 are the common registers.
- R4: In interrupt, supervisor, abort and undefined modes, R13 and R14 address a private pair for that mode. R0 to R12 and R15 are the common registers.
- R5: User and system modes see the same registers R0 to R15.
- R6: R15 is one register shared by every mode. pc_o always shows it, and it is readable as address 15 in any mode.
- R7: Reads are combinational. A write lands on the rising clock edge, so a read of the written register in the write's own cycle returns the old value.
- R8: When call_i is high, R14 of the current mode receives the R15 value from before the edge, even when the PC is also written in that cycle.
- R9: When lr_we_i is high, lr_data_i goes to R14 of lr_mode_i if lr_mode_sel_i is 1, otherwise to R14 of mode_i.
- R10: When pc_we_i and a general write to R15 happen in the same cycle, pc_data_i wins.
- R11: For writes that hit the same physical R14, the link port wins over call_i, and call_i wins over the general write port.
- R12: The two read ports are independent. Each returns its own addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current operating mode code |
| rd_a_addr_i | input | 4 | Read port A register number |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 4 | Read port B register number |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General write enable |
| wr_addr_i | input | 4 | General write register number |
| wr_data_i | input | 32 | General write data |
| pc_we_i | input | 1 | PC write enable |
| pc_data_i | input | 32 | PC write data |
| call_i | input | 1 | Copy R15 into R14 of the current mode |
| lr_we_i | input | 1 | Link port write enable |
| lr_mode_sel_i | input | 1 | Use lr_mode_i instead of mode_i for the link port |
| lr_mode_i | input | 5 | Target mode for the link port |
| lr_data_i | input | 32 | Link port data |
| pc_o | output | 32 | Current program counter |

## Verification
A wrong bank decode shows up on the very next combinational read from the mode that should have been isolated. A value written in one mode either appears in another mode, or fails to appear where it is shared. Because of this, the bench writes distinct values per bank and then reads them back across all modes. A broken write priority or a lost PC capture is visible one clock after the colliding cycle, as the wrong word on a read of R14 or R15, or on pc_o.

// File: rtl/bank_rf_pkg.sv
`timescale 1ns/1ps
package bank_rf_pkg;
  localparam int DATA_W   = 32;
  localparam int ARCH_W   = 4;
  localparam int MODE_W   = 5;
  localparam int NUM_ARCH = 2 ** ARCH_W;
  localparam int PC_ARCH  = NUM_ARCH - 1;
  localparam int LR_ARCH  = PC_ARCH - 1;
  localparam int SP_ARCH  = PC_ARCH - 2;
  localparam int FIQ_LO   = 8;
  localparam int NUM_EXC  = 4;
  localparam int EXC_PAIR = PC_ARCH - SP_ARCH;
  localparam int FIQ_BASE = NUM_ARCH;
  localparam int EXC_BASE = FIQ_BASE + (PC_ARCH - FIQ_LO);
  localparam int NUM_PHYS = EXC_BASE + NUM_EXC * EXC_PAIR;
  localparam int PHYS_W   = $clog2(NUM_PHYS);

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  // exception classes must stay contiguous from CLS_IRQ: bank index derives from order
  typedef enum logic [2:0] {
    CLS_USR, CLS_FIQ, CLS_IRQ, CLS_SVC, CLS_ABT, CLS_UND
  } mode_cls_e;
endpackage

// File: rtl/bank_rf_decode.sv
`timescale 1ns/1ps
module bank_rf_decode
  import bank_rf_pkg::*;
#(
  parameter int MW = MODE_W
) (
  input  logic [MW-1:0] mode_i,
  output mode_cls_e     cls_o
);
  always_comb begin
    unique case (mode_i)
      MODE_FIQ: cls_o = CLS_FIQ;
      MODE_IRQ: cls_o = CLS_IRQ;
      MODE_SVC: cls_o = CLS_SVC;
      MODE_ABT: cls_o = CLS_ABT;
      MODE_UND: cls_o = CLS_UND;
      default:  cls_o = CLS_USR; // user, system and unknown codes
    endcase
  end
endmodule

// File: rtl/bank_rf_map.sv
`timescale 1ns/1ps
module bank_rf_map
  import bank_rf_pkg::*;
#(
  parameter int AW = ARCH_W,
  parameter int PW = PHYS_W
) (
  input  mode_cls_e     cls_i,
  input  logic [AW-1:0] arch_i,
  output logic [PW-1:0] phys_o
);
  int a;
  int idx;

  always_comb begin
    a   = int'(arch_i);
    idx = a;
    if (a != PC_ARCH) begin
      if (cls_i == CLS_FIQ && a >= FIQ_LO) begin
        idx = FIQ_BASE + a - FIQ_LO;
      end else if (cls_i != CLS_USR && cls_i != CLS_FIQ && a >= SP_ARCH) begin
        idx = EXC_BASE + EXC_PAIR * (int'(cls_i) - int'(CLS_IRQ)) + a - SP_ARCH;
      end
    end
    phys_o = PW'(idx);
  end
endmodule

// File: rtl/bank_rf_store.sv
`timescale 1ns/1ps
module bank_rf_store
  import bank_rf_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int NUM    = NUM_PHYS,
  parameter int PW     = PHYS_W,
  parameter int PC_IDX = PC_ARCH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gen_we_i,
  input  logic [PW-1:0] gen_idx_i,
  input  logic [DW-1:0] gen_data_i,
  input  logic          call_we_i,
  input  logic [PW-1:0] call_idx_i,
  input  logic          lr_we_i,
  input  logic [PW-1:0] lr_idx_i,
  input  logic [DW-1:0] lr_data_i,
  input  logic          pc_we_i,
  input  logic [DW-1:0] pc_data_i,
  input  logic [PW-1:0] rd_a_idx_i,
  input  logic [PW-1:0] rd_b_idx_i,
  output logic [DW-1:0] rd_a_data_o,
  output logic [DW-1:0] rd_b_data_o,
  output logic [DW-1:0] pc_o
);
  localparam int SLOTS = 2 ** PW;

  logic [DW-1:0] regs [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g >= NUM) begin : g_pad
      assign regs[g] = '0;
    end else if (g == PC_IDX) begin : g_pc
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                    q <= '0;
        else if (pc_we_i)                               q <= pc_data_i;
        else if (gen_we_i && gen_idx_i == PW'(g))       q <= gen_data_i;
      end
      assign regs[g] = q;
    end else begin : g_gpr
      logic [DW-1:0] q;
      logic lr_hit, call_hit, gen_hit;
      assign lr_hit   = lr_we_i   && lr_idx_i   == PW'(g);
      assign call_hit = call_we_i && call_idx_i == PW'(g);
      assign gen_hit  = gen_we_i  && gen_idx_i  == PW'(g);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= '0;
        else if (lr_hit)   q <= lr_data_i;
        else if (call_hit) q <= regs[PC_IDX]; // pre-edge PC
        else if (gen_hit)  q <= gen_data_i;
      end
      assign regs[g] = q;
    end
  end

  assign rd_a_data_o = regs[rd_a_idx_i];
  assign rd_b_data_o = regs[rd_b_idx_i];
  assign pc_o        = regs[PC_IDX];
endmodule

// File: rtl/bank_rf.sv
`timescale 1ns/1ps
module bank_rf
  import bank_rf_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ARCH_W,
  parameter int MW = MODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [MW-1:0] mode_i,
  input  logic [AW-1:0] rd_a_addr_i,
  output logic [DW-1:0] rd_a_data_o,
  input  logic [AW-1:0] rd_b_addr_i,
  output logic [DW-1:0] rd_b_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          pc_we_i,
  input  logic [DW-1:0] pc_data_i,
  input  logic          call_i,
  input  logic          lr_we_i,
  input  logic          lr_mode_sel_i,
  input  logic [MW-1:0] lr_mode_i,
  input  logic [DW-1:0] lr_data_i,
  output logic [DW-1:0] pc_o
);
  localparam int NMAP   = 5;
  localparam int M_RDA  = 0;
  localparam int M_RDB  = 1;
  localparam int M_WR   = 2;
  localparam int M_CALL = 3;
  localparam int M_LR   = 4;

  mode_cls_e     cls_cur, cls_lr;
  logic [MW-1:0] lr_mode_eff;

  mode_cls_e         map_cls  [NMAP];
  logic [AW-1:0]     map_arch [NMAP];
  logic [PHYS_W-1:0] map_phys [NMAP];

  assign lr_mode_eff = lr_mode_sel_i ? lr_mode_i : mode_i;

  bank_rf_decode #(.MW(MW)) u_dec_cur (.mode_i(mode_i),      .cls_o(cls_cur));
  bank_rf_decode #(.MW(MW)) u_dec_lr  (.mode_i(lr_mode_eff), .cls_o(cls_lr));

  assign map_cls[M_RDA]   = cls_cur;
  assign map_cls[M_RDB]   = cls_cur;
  assign map_cls[M_WR]    = cls_cur;
  assign map_cls[M_CALL]  = cls_cur;
  assign map_cls[M_LR]    = cls_lr;
  assign map_arch[M_RDA]  = rd_a_addr_i;
  assign map_arch[M_RDB]  = rd_b_addr_i;
  assign map_arch[M_WR]   = wr_addr_i;
  assign map_arch[M_CALL] = AW'(LR_ARCH);
  assign map_arch[M_LR]   = AW'(LR_ARCH);

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    bank_rf_map #(.AW(AW), .PW(PHYS_W)) u_map (
      .cls_i (map_cls[g]),
      .arch_i(map_arch[g]),
      .phys_o(map_phys[g])
    );
  end

  bank_rf_store #(
    .DW(DW), .NUM(NUM_PHYS), .PW(PHYS_W), .PC_IDX(PC_ARCH)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gen_we_i   (wr_en_i),
    .gen_idx_i  (map_phys[M_WR]),
    .gen_data_i (wr_data_i),
    .call_we_i  (call_i),
    .call_idx_i (map_phys[M_CALL]),
    .lr_we_i    (lr_we_i),
    .lr_idx_i   (map_phys[M_LR]),
    .lr_data_i  (lr_data_i),
    .pc_we_i    (pc_we_i),
    .pc_data_i  (pc_data_i),
    .rd_a_idx_i (map_phys[M_RDA]),
    .rd_b_idx_i (map_phys[M_RDB]),
    .rd_a_data_o(rd_a_data_o),
    .rd_b_data_o(rd_b_data_o),
    .pc_o       (pc_o)
  );
endmodule

// File: rtl/bank_rf_chk.sv
`timescale 1ns/1ps
module bank_rf_chk #(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int MW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [MW-1:0] mode_i,
  input logic [AW-1:0] rd_a_addr_i,
  input logic [DW-1:0] rd_a_data_o,
  input logic [AW-1:0] rd_b_addr_i,
  input logic [DW-1:0] rd_b_data_o,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic          pc_we_i,
  input logic [DW-1:0] pc_data_i,
  input logic          call_i,
  input logic          lr_we_i,
  input logic [DW-1:0] pc_o
);
  localparam logic [AW-1:0] PC_A = '1;
  localparam logic [AW-1:0] LR_A = PC_A - 1'b1;

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_o == '0 && rd_a_data_o == '0 && rd_b_data_o == '0));

  assert_pc_alias_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == PC_A) |-> (rd_a_data_o == pc_o));

  assert_pc_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pc_we_i && !(wr_en_i && wr_addr_i == PC_A)) |=> $stable(pc_o));

  assert_pc_port_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_i |=> (pc_o == $past(pc_data_i)));

  assert_call_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !lr_we_i && !(wr_en_i && wr_addr_i == LR_A))
      |=> ((rd_a_addr_i == LR_A && $stable(mode_i)) |-> (rd_a_data_o == $past(pc_o))));

  assert_ports_agree_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == rd_b_addr_i) |-> (rd_a_data_o == rd_b_data_o));
endmodule

bind bank_rf bank_rf_chk #(.DW(DW), .AW(AW), .MW(MW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .rd_a_addr_i(rd_a_addr_i),
  .rd_a_data_o(rd_a_data_o),
  .rd_b_addr_i(rd_b_addr_i),
  .rd_b_data_o(rd_b_data_o),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .pc_we_i    (pc_we_i),
  .pc_data_i  (pc_data_i),
  .call_i     (call_i),
  .lr_we_i    (lr_we_i),
  .pc_o       (pc_o)
);

// File: tb/bank_rf_tb_top.sv
`timescale 1ns/1ps
module bank_rf_tb_top;
  import bank_rf_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  mode_i = MODE_USR;
  logic [3:0]  rd_a_addr_i = '0, rd_b_addr_i = '0, wr_addr_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o, pc_o;
  logic        wr_en_i = 1'b0, pc_we_i = 1'b0, call_i = 1'b0;
  logic        lr_we_i = 1'b0, lr_mode_sel_i = 1'b0;
  logic [4:0]  lr_mode_i = MODE_USR;
  logic [31:0] wr_data_i = '0, pc_data_i = '0, lr_data_i = '0;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bank_rf dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .rd_a_addr_i(rd_a_addr_i), .rd_a_data_o(rd_a_data_o),
    .rd_b_addr_i(rd_b_addr_i), .rd_b_data_o(rd_b_data_o),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pc_we_i(pc_we_i), .pc_data_i(pc_data_i), .call_i(call_i),
    .lr_we_i(lr_we_i), .lr_mode_sel_i(lr_mode_sel_i), .lr_mode_i(lr_mode_i),
    .lr_data_i(lr_data_i), .pc_o(pc_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic expect_rd(input string tag, input logic [4:0] m, input logic [3:0] a,
                           input logic [31:0] exp);
    mode_i = m; rd_a_addr_i = a; rd_b_addr_i = a;
    #0.2;
    chk(tag, rd_a_data_o, exp);
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
    wr_en_i = 0; pc_we_i = 0; call_i = 0; lr_we_i = 0; lr_mode_sel_i = 0;
  endtask

  task automatic wr(input logic [4:0] m, input logic [3:0] a, input logic [31:0] d);
    mode_i = m; wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 pc_o", pc_o, 32'h0);
    expect_rd("R1 usr r0",  MODE_USR, 4'd0,  32'h0);
    expect_rd("R1 fiq r8",  MODE_FIQ, 4'd8,  32'h0);
    expect_rd("R1 irq r13", MODE_IRQ, 4'd13, 32'h0);
    expect_rd("R1 und r14", MODE_UND, 4'd14, 32'h0);
    expect_rd("R1 svc r15", MODE_SVC, 4'd15, 32'h0);
  endtask

  task automatic t_common();
    for (int i = 0; i < 13; i++) wr(MODE_USR, 4'(i), 32'h1000_0000 + i);
    for (int i = 0; i < 13; i++) expect_rd("R5 sys sees usr", MODE_SYS, 4'(i), 32'h1000_0000 + i);
    for (int i = 0; i < 13; i++) expect_rd("R4 irq common", MODE_IRQ, 4'(i), 32'h1000_0000 + i);
    for (int i = 0; i < 8; i++)  expect_rd("R3 fiq low common", MODE_FIQ, 4'(i), 32'h1000_0000 + i);
    expect_rd("R3 fiq r8 private", MODE_FIQ, 4'd8, 32'h0);
    wr(MODE_SYS, 4'd13, 32'hAAAA_0013);
    wr(MODE_USR, 4'd14, 32'hAAAA_0014);
    expect_rd("R5 usr r13 from sys", MODE_USR, 4'd13, 32'hAAAA_0013);
    expect_rd("R5 sys r14 from usr", MODE_SYS, 4'd14, 32'hAAAA_0014);
    expect_rd("R4 svc r13 private", MODE_SVC, 4'd13, 32'h0);
  endtask

  task automatic t_fiq();
    for (int i = 8; i < 15; i++) wr(MODE_FIQ, 4'(i), 32'hF000_0000 + i);
    for (int i = 8; i < 15; i++) expect_rd("R3 fiq bank", MODE_FIQ, 4'(i), 32'hF000_0000 + i);
    for (int i = 8; i < 13; i++) expect_rd("R3 usr untouched", MODE_USR, 4'(i), 32'h1000_0000 + i);
    expect_rd("R3 usr r13 untouched", MODE_USR, 4'd13, 32'hAAAA_0013);
    expect_rd("R3 irq r8 common",     MODE_IRQ, 4'd8,  32'h1000_0008);
  endtask

  task automatic t_exc_banks();
    logic [4:0] ms [4] = '{MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND};
    for (int k = 0; k < 4; k++) begin
      wr(ms[k], 4'd13, {8'hE0 + 8'(k), 16'h0, 8'd13});
      wr(ms[k], 4'd14, {8'hE0 + 8'(k), 16'h0, 8'd14});
    end
    for (int k = 0; k < 4; k++) begin
      expect_rd("R4 exc r13", ms[k], 4'd13, {8'hE0 + 8'(k), 16'h0, 8'd13});
      expect_rd("R4 exc r14", ms[k], 4'd14, {8'hE0 + 8'(k), 16'h0, 8'd14});
      expect_rd("R4 exc r12 common", ms[k], 4'd12, 32'h1000_000C);
    end
    expect_rd("R4 usr r13 kept", MODE_USR, 4'd13, 32'hAAAA_0013);
    expect_rd("R4 fiq r13 kept", MODE_FIQ, 4'd13, 32'hF000_000D);
  endtask

  task automatic t_unknown();
    expect_rd("R2 code 00000 as usr", 5'b00000, 4'd13, 32'hAAAA_0013);
    expect_rd("R2 code 10100 as usr", 5'b10100, 4'd8,  32'h1000_0008);
    wr(5'b01010, 4'd14, 32'h0BAD_0014);
    expect_rd("R2 unknown write to usr", MODE_USR, 4'd14, 32'h0BAD_0014);
    expect_rd("R2 unknown write not fiq", MODE_FIQ, 4'd14, 32'hF000_000E);
  endtask

  task automatic t_rd_wr_same_cycle();
    @(posedge clk_i); #1;
    mode_i = MODE_USR; rd_a_addr_i = 4'd3; rd_b_addr_i = 4'd5;
    wr_en_i = 1; wr_addr_i = 4'd3; wr_data_i = 32'h3333_3333;
    #0.2;
    chk("R7 old value before edge", rd_a_data_o, 32'h1000_0003);
    chk("R12 port b independent",   rd_b_data_o, 32'h1000_0005);
    tick();
    chk("R7 new value after edge",  rd_a_data_o, 32'h3333_3333);
    chk("R12 port b unchanged",     rd_b_data_o, 32'h1000_0005);
  endtask

  task automatic t_pc();
    pc_we_i = 1; pc_data_i = 32'h0000_0100; tick();
    chk("R6 pc_o", pc_o, 32'h0000_0100);
    expect_rd("R6 fiq r15", MODE_FIQ, 4'd15, 32'h0000_0100);
    expect_rd("R6 und r15", MODE_UND, 4'd15, 32'h0000_0100);
    pc_we_i = 1; pc_data_i = 32'h0000_0200;
    wr_en_i = 1; wr_addr_i = 4'd15; wr_data_i = 32'hDEAD_0000; mode_i = MODE_USR;
    tick();
    chk("R10 pc port wins", pc_o, 32'h0000_0200);
    wr(MODE_IRQ, 4'd15, 32'h0000_0300);
    expect_rd("R6 general write r15 shared", MODE_USR, 4'd15, 32'h0000_0300);
  endtask

  task automatic t_call();
    mode_i = MODE_SVC; rd_a_addr_i = 4'd14; call_i = 1; tick();
    expect_rd("R8 svc r14 gets pc", MODE_SVC, 4'd14, 32'h0000_0300);
    expect_rd("R8 usr r14 kept",    MODE_USR, 4'd14, 32'h0BAD_0014);
    expect_rd("R8 irq r14 kept",    MODE_IRQ, 4'd14, 32'hE000_000E);
    mode_i = MODE_ABT; rd_a_addr_i = 4'd14;
    call_i = 1; pc_we_i = 1; pc_data_i = 32'h0000_0400; tick();
    expect_rd("R8 old pc captured", MODE_ABT, 4'd14, 32'h0000_0300);
    chk("R8 pc updated", pc_o, 32'h0000_0400);
  endtask

  task automatic t_link();
    mode_i = MODE_USR; lr_we_i = 1; lr_mode_sel_i = 1; lr_mode_i = MODE_IRQ;
    lr_data_i = 32'h1111_0014; tick();
    expect_rd("R9 override irq r14", MODE_IRQ, 4'd14, 32'h1111_0014);
    expect_rd("R9 usr r14 kept",     MODE_USR, 4'd14, 32'h0BAD_0014);
    mode_i = MODE_FIQ; lr_we_i = 1; lr_mode_sel_i = 0; lr_mode_i = MODE_UND;
    lr_data_i = 32'h2222_0014; tick();
    expect_rd("R9 current fiq r14",    MODE_FIQ, 4'd14, 32'h2222_0014);
    expect_rd("R9 lr_mode ignored",    MODE_UND, 4'd14, 32'hE300_000E);
  endtask

  task automatic t_prio();
    mode_i = MODE_UND; lr_we_i = 1; lr_data_i = 32'h5555_0014; call_i = 1;
    wr_en_i = 1; wr_addr_i = 4'd14; wr_data_i = 32'h6666_0014; tick();
    expect_rd("R11 link beats call and write", MODE_UND, 4'd14, 32'h5555_0014);
    mode_i = MODE_UND; call_i = 1;
    wr_en_i = 1; wr_addr_i = 4'd14; wr_data_i = 32'h6666_0014; tick();
    expect_rd("R11 call beats write", MODE_UND, 4'd14, 32'h0000_0400);
    mode_i = MODE_UND; lr_we_i = 1; lr_mode_sel_i = 1; lr_mode_i = MODE_IRQ;
    lr_data_i = 32'h7777_0014; call_i = 1;
    wr_en_i = 1; wr_addr_i = 4'd13; wr_data_i = 32'h6666_0013; tick();
    expect_rd("R11 disjoint link lands",  MODE_IRQ, 4'd14, 32'h7777_0014);
    expect_rd("R11 disjoint call lands",  MODE_UND, 4'd14, 32'h0000_0400);
    expect_rd("R11 disjoint write lands", MODE_UND, 4'd13, 32'h6666_0013);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_common();
    t_fiq();
    t_exc_banks();
    t_unknown();
    t_rd_wr_same_cycle();
    t_pc();
    t_call();
    t_link();
    t_prio();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule